// File: doc/BRIEF.md
# Interrupt Translation Command Queue Engine

This engine works through a circular queue of 32-byte commands held in memory. Software places commands in the queue, then moves the write pointer forward through a small register port. The engine reads each command one 64-bit little-endian doubleword at a time over a read port with a valid/ready request and a separate response. It decodes the opcode and acts on it. Map-device and map-collection commands become update requests on a table-writer handshake. A sync command produces a one-cycle completion pulse. Every other opcode retires without effect.

After each command retires, the read pointer moves forward and wraps at the configured entry count. Map commands whose operands fall outside the configured limits are dropped, but they still count as retired. A failed memory read, or a failed table write, freezes the read pointer and sets a sticky stall flag. The engine then stops until the write pointer is written again.

Top module: `cmdq_engine`

## Requirements
- R1: After reset `rd_ptr_o`, `wr_ptr_o`, `busy_o`, `mem_req_valid_o`, `tbl_valid_o`, `sync_o` and `wr_err_o` are all zero.
- R2: A write with `reg_addr_i`=1 loads the write pointer. The offset is taken from `reg_wdata_i` bits starting at bit 5 (15 bits by default), and bit 0 is kept as a retry bit; `wr_ptr_o` shows both in the same positions. Processing starts only if the enable is set and the new offset differs from the read offset.
- R3: A write-pointer write whose offset is greater than or equal to `max_entries_i` is rejected. `wr_err_o` is high for the one cycle after the write, `wr_ptr_o` does not change, and no fetch is issued.
- R4: Doubleword d of the command at read offset n is fetched from `base_addr_i + 32*n + 8*d`. The opcode is bits 7:0 of doubleword 0.
- R5: Map-device (opcode 0x08) fetches doublewords 0, 1 and 2. It issues a table request with `tbl_coll_o`=0, id = dw0[63:32], size = dw1[4:0], table address = dw2[51:8] and valid = dw2[63].
- R6: Map-collection (opcode 0x09) fetches doublewords 0 and 2. It issues a table request with `tbl_coll_o`=1, id = dw2[15:0], target CPU = dw2[31:16] and valid = dw2[63].
- R7: A map-device command whose id exceeds `max_dev_id_i`, or whose size exceeds `id_bits_i`, is retired with no table request. The same applies to a map-collection command whose id exceeds `max_coll_id_i` or whose CPU exceeds `num_cpu_i`. Equal values are in range.
- R8: Sync (opcode 0x05) fetches doublewords 0 and 2 and pulses `sync_o` for one cycle, with `sync_cpu_o` = dw2[31:16]. Opcodes 0x03, 0x04, 0x0A, 0x0B, 0x0F and all unknown codes fetch only doubleword 0 and retire with no table request and no sync pulse.
- R9: Each retired command moves the read offset forward by one, modulo `max_entries_i`. Processing continues until the read offset equals the write offset.
- R10: A read response with `mem_rsp_err_i`, or a table handshake with `tbl_err_i`, sets `rd_ptr_o` bit 0, leaves the read offset unchanged and drops `busy_o`. The bit stays set. The command is retried on the next accepted write-pointer write.
- R11: A write-pointer write accepted while `busy_o` is high takes effect, and the engine keeps running up to the new offset.
- R12: With the enable (`reg_addr_i`=0, bit 0) clear, a write-pointer write starts nothing. Setting the enable alone also starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | 0 = control, 1 = write pointer |
| reg_wdata_i | input | 32 | Register write data |
| base_addr_i | input | ADDR_W | Queue base byte address |
| max_entries_i | input | OFF_W+1 | Queue entry count |
| max_dev_id_i | input | 32 | Largest accepted device id |
| id_bits_i | input | 5 | Largest accepted size field |
| max_coll_id_i | input | 16 | Largest accepted collection id |
| num_cpu_i | input | 16 | Largest accepted target CPU |
| rd_ptr_o | output | 32 | Read pointer: offset from bit 5, stall flag at bit 0 |
| wr_ptr_o | output | 32 | Write pointer: offset from bit 5, retry bit at bit 0 |
| wr_err_o | output | 1 | Rejected write-pointer write |
| busy_o | output | 1 | Engine running |
| mem_req_valid_o | output | 1 | Read request valid |
| mem_req_ready_i | input | 1 | Read request ready |
| mem_addr_o | output | ADDR_W | Read byte address |
| mem_rsp_valid_i | input | 1 | Read response valid |
| mem_rsp_data_i | input | 64 | Read response doubleword |
| mem_rsp_err_i | input | 1 | Read response error |
| tbl_valid_o | output | 1 | Table update request valid |
| tbl_ready_i | input | 1 | Table update accepted |
| tbl_err_i | input | 1 | Table update failed (sampled with ready) |
| tbl_coll_o | output | 1 | 0 = device table, 1 = collection table |
| tbl_id_o | output | 32 | Entry id |
| tbl_map_valid_o | output | 1 | Mapping valid flag |
| tbl_size_o | output | 5 | Device id-size field |
| tbl_itt_o | output | 44 | Device table address field |
| tbl_cpu_o | output | 16 | Collection target CPU |
| sync_o | output | 1 | Sync completion pulse |
| sync_cpu_o | output | 16 | Sync target CPU |

## Verification
The bench builds the engine with ADDR_W=32 and OFF_W=4, and sets the entry count to 8. This lets a few commands carry the read offset across the wrap point, and lets an offset of 8 or 9 test the rejection limit. The operand limits are kept small (device 100, size 10, collection 15, CPU 3). With these values, commands sitting exactly on a limit and one past it both fit in the queue. The memory model answers with varying latency and ready gaps, and can inject an error on a chosen address.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;
  localparam int OFF_LSB  = 5;   // offset field position in pointer registers
  localparam int DW_SHIFT = 3;   // 8 bytes per doubleword
  localparam int PTR_W    = 32;

  localparam logic [7:0] OPC_INT     = 8'h03;
  localparam logic [7:0] OPC_CLEAR   = 8'h04;
  localparam logic [7:0] OPC_SYNC    = 8'h05;
  localparam logic [7:0] OPC_MAPD    = 8'h08;
  localparam logic [7:0] OPC_MAPC    = 8'h09;
  localparam logic [7:0] OPC_MAPTI   = 8'h0A;
  localparam logic [7:0] OPC_MAPI    = 8'h0B;
  localparam logic [7:0] OPC_DISCARD = 8'h0F;

  localparam logic [1:0] DW_DONE = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_EXEC, ST_WAIT_TBL, ST_ADVANCE
  } state_e;

  typedef struct packed {
    logic        coll;
    logic [31:0] id;
    logic        map_valid;
    logic [4:0]  size;
    logic [43:0] itt;
    logic [15:0] cpu;
  } tbl_req_t;

  // next doubleword to fetch after idx, or DW_DONE
  function automatic logic [1:0] dw_after(input logic [7:0] op, input logic [1:0] idx);
    logic [1:0] r;
    r = DW_DONE;
    if (idx == 2'd0) begin
      if (op == OPC_MAPD) r = 2'd1;
      else if (op == OPC_MAPC || op == OPC_SYNC) r = 2'd2;
    end else if (idx == 2'd1) begin
      r = 2'd2;
    end
    return r;
  endfunction
endpackage

// File: rtl/cmdq_ptr_regs.sv
module cmdq_ptr_regs
  import cmdq_pkg::*;
#(
  parameter int OFF_W = 15
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic               addr_i,
  input  logic [PTR_W-1:0]   wdata_i,
  input  logic [OFF_W:0]     max_entries_i,
  input  logic               adv_i,
  input  logic               stall_i,
  output logic               enable_o,
  output logic [OFF_W-1:0]   wr_off_o,
  output logic [OFF_W-1:0]   rd_off_o,
  output logic [OFF_W-1:0]   rd_next_o,
  output logic               kick_o,
  output logic               wr_err_o,
  output logic [PTR_W-1:0]   rd_ptr_o,
  output logic [PTR_W-1:0]   wr_ptr_o
);
  localparam int CNT_W = OFF_W + 1;

  logic             en_q, retry_q, stall_q, kick_q, err_q;
  logic [OFF_W-1:0] wr_off_q, rd_off_q, wr_new;
  logic [CNT_W-1:0] rd_inc;
  logic             wr_bad, ctrl_we, ptr_we;

  assign wr_new  = wdata_i[OFF_LSB +: OFF_W];
  assign wr_bad  = {1'b0, wr_new} >= max_entries_i;
  assign ctrl_we = we_i && !addr_i;
  assign ptr_we  = we_i && addr_i;
  assign rd_inc  = {1'b0, rd_off_q} + CNT_W'(1);
  assign rd_next_o = (rd_inc >= max_entries_i) ? '0 : rd_inc[OFF_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= 1'b0;
      retry_q  <= 1'b0;
      stall_q  <= 1'b0;
      kick_q   <= 1'b0;
      err_q    <= 1'b0;
      wr_off_q <= '0;
      rd_off_q <= '0;
    end else begin
      if (ctrl_we) en_q <= wdata_i[0];
      if (ptr_we && !wr_bad) begin
        wr_off_q <= wr_new;
        retry_q  <= wdata_i[0];
      end
      kick_q <= ptr_we && !wr_bad;
      err_q  <= ptr_we && wr_bad;
      if (adv_i)   rd_off_q <= rd_next_o;
      if (stall_i) stall_q  <= 1'b1;
    end
  end

  always_comb begin
    rd_ptr_o = '0;
    rd_ptr_o[OFF_LSB +: OFF_W] = rd_off_q;
    rd_ptr_o[0] = stall_q;
    wr_ptr_o = '0;
    wr_ptr_o[OFF_LSB +: OFF_W] = wr_off_q;
    wr_ptr_o[0] = retry_q;
  end

  assign enable_o = en_q;
  assign wr_off_o = wr_off_q;
  assign rd_off_o = rd_off_q;
  assign kick_o   = kick_q;
  assign wr_err_o = err_q;
endmodule

// File: rtl/cmdq_decode.sv
module cmdq_decode
  import cmdq_pkg::*;
(
  input  logic [63:0] dw0_i,
  input  logic [63:0] dw1_i,
  input  logic [63:0] dw2_i,
  input  logic [31:0] max_dev_id_i,
  input  logic [4:0]  id_bits_i,
  input  logic [15:0] max_coll_id_i,
  input  logic [15:0] num_cpu_i,
  output logic        is_map_o,
  output logic        is_sync_o,
  output logic        in_range_o,
  output tbl_req_t    req_o,
  output logic [15:0] sync_cpu_o
);
  logic [7:0] op;
  assign op = dw0_i[7:0];

  always_comb begin
    req_o      = '0;
    in_range_o = 1'b0;
    is_map_o   = 1'b0;
    if (op == OPC_MAPD) begin
      is_map_o        = 1'b1;
      req_o.id        = dw0_i[63:32];
      req_o.size      = dw1_i[4:0];
      req_o.itt       = dw2_i[51:8];
      req_o.map_valid = dw2_i[63];
      in_range_o      = (dw0_i[63:32] <= max_dev_id_i) && (dw1_i[4:0] <= id_bits_i);
    end else if (op == OPC_MAPC) begin
      is_map_o        = 1'b1;
      req_o.coll      = 1'b1;
      req_o.id        = {16'h0, dw2_i[15:0]};
      req_o.cpu       = dw2_i[31:16];
      req_o.map_valid = dw2_i[63];
      in_range_o      = (dw2_i[15:0] <= max_coll_id_i) && (dw2_i[31:16] <= num_cpu_i);
    end
  end

  assign is_sync_o  = (op == OPC_SYNC);
  assign sync_cpu_o = dw2_i[31:16];
endmodule

// File: rtl/cmdq_engine.sv
module cmdq_engine
  import cmdq_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int OFF_W  = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic              reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  input  logic [OFF_W:0]    max_entries_i,
  input  logic [31:0]       max_dev_id_i,
  input  logic [4:0]        id_bits_i,
  input  logic [15:0]       max_coll_id_i,
  input  logic [15:0]       num_cpu_i,
  output logic [31:0]       rd_ptr_o,
  output logic [31:0]       wr_ptr_o,
  output logic              wr_err_o,
  output logic              busy_o,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_rsp_valid_i,
  input  logic [63:0]       mem_rsp_data_i,
  input  logic              mem_rsp_err_i,
  output logic              tbl_valid_o,
  input  logic              tbl_ready_i,
  input  logic              tbl_err_i,
  output logic              tbl_coll_o,
  output logic [31:0]       tbl_id_o,
  output logic              tbl_map_valid_o,
  output logic [4:0]        tbl_size_o,
  output logic [43:0]       tbl_itt_o,
  output logic [15:0]       tbl_cpu_o,
  output logic              sync_o,
  output logic [15:0]       sync_cpu_o
);
  state_e           state_q, state_d;
  logic [1:0]       idx_q, idx_d, nxt_idx;
  logic             sent_q, sent_d, ld;
  logic [63:0]      dw_q [3];
  logic             adv, stall, enable, kick;
  logic [OFF_W-1:0] wr_off, rd_off, rd_next;
  logic             is_map, is_sync, in_range;
  tbl_req_t         req;

  cmdq_ptr_regs #(.OFF_W(OFF_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .max_entries_i, .adv_i(adv), .stall_i(stall),
    .enable_o(enable), .wr_off_o(wr_off), .rd_off_o(rd_off), .rd_next_o(rd_next),
    .kick_o(kick), .wr_err_o, .rd_ptr_o, .wr_ptr_o
  );

  cmdq_decode u_dec (
    .dw0_i(dw_q[0]), .dw1_i(dw_q[1]), .dw2_i(dw_q[2]),
    .max_dev_id_i, .id_bits_i, .max_coll_id_i, .num_cpu_i,
    .is_map_o(is_map), .is_sync_o(is_sync), .in_range_o(in_range),
    .req_o(req), .sync_cpu_o
  );

  assign nxt_idx = dw_after((idx_q == 2'd0) ? mem_rsp_data_i[7:0] : dw_q[0][7:0], idx_q);

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    sent_d  = sent_q;
    adv     = 1'b0;
    stall   = 1'b0;
    ld      = 1'b0;
    mem_req_valid_o = 1'b0;
    tbl_valid_o     = 1'b0;
    sync_o          = 1'b0;
    unique case (state_q)
      ST_IDLE: if (kick && enable && wr_off != rd_off) begin
        state_d = ST_FETCH;
        idx_d   = 2'd0;
        sent_d  = 1'b0;
      end
      ST_FETCH: begin
        mem_req_valid_o = !sent_q;
        if (!sent_q && mem_req_ready_i) sent_d = 1'b1;
        // response only counted once the request was accepted
        if (sent_q && mem_rsp_valid_i) begin
          if (mem_rsp_err_i) begin
            stall   = 1'b1;
            state_d = ST_IDLE;
          end else begin
            ld = 1'b1;
            if (nxt_idx == DW_DONE) state_d = ST_EXEC;
            else begin
              idx_d  = nxt_idx;
              sent_d = 1'b0;
            end
          end
        end
      end
      ST_EXEC: begin
        if (is_map && in_range) state_d = ST_WAIT_TBL;
        else begin
          sync_o  = is_sync;
          state_d = ST_ADVANCE;
        end
      end
      ST_WAIT_TBL: begin
        tbl_valid_o = 1'b1;
        if (tbl_ready_i) begin
          if (tbl_err_i) begin
            stall   = 1'b1;
            state_d = ST_IDLE;
          end else state_d = ST_ADVANCE;
        end
      end
      ST_ADVANCE: begin
        adv = 1'b1;
        if (enable && wr_off != rd_next) begin
          state_d = ST_FETCH;
          idx_d   = 2'd0;
          sent_d  = 1'b0;
        end else state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      sent_q  <= 1'b0;
      for (int i = 0; i < 3; i++) dw_q[i] <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      sent_q  <= sent_d;
      if (ld) dw_q[idx_q] <= mem_rsp_data_i;
    end
  end

  assign mem_addr_o = base_addr_i
                    + ADDR_W'({rd_off, {OFF_LSB{1'b0}}})
                    + ADDR_W'({idx_q, {DW_SHIFT{1'b0}}});
  assign busy_o          = (state_q != ST_IDLE);
  assign tbl_coll_o      = req.coll;
  assign tbl_id_o        = req.id;
  assign tbl_map_valid_o = req.map_valid;
  assign tbl_size_o      = req.size;
  assign tbl_itt_o       = req.itt;
  assign tbl_cpu_o       = req.cpu;
endmodule

// File: rtl/cmdq_engine_chk.sv
module cmdq_engine_chk #(
  parameter int ADDR_W = 48,
  parameter int OFF_W  = 15
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [31:0]       rd_ptr_o,
  input logic [31:0]       wr_ptr_o,
  input logic              wr_err_o,
  input logic              busy_o,
  input logic              mem_req_valid_o,
  input logic              mem_req_ready_i,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              tbl_valid_o,
  input logic              tbl_ready_i,
  input logic              tbl_coll_o,
  input logic [31:0]       tbl_id_o,
  input logic [4:0]        tbl_size_o,
  input logic [15:0]       tbl_cpu_o,
  input logic              sync_o,
  input logic [OFF_W:0]    max_entries_i,
  input logic [31:0]       max_dev_id_i,
  input logic [4:0]        id_bits_i,
  input logic [15:0]       max_coll_id_i,
  input logic [15:0]       num_cpu_i
);
  logic [OFF_W-1:0] rd_off, prev_rd, prev_nxt;
  logic [OFF_W:0]   prev_inc;

  assign rd_off   = rd_ptr_o[5 +: OFF_W];
  assign prev_inc = {1'b0, prev_rd} + (OFF_W+1)'(1);
  assign prev_nxt = (prev_inc >= max_entries_i) ? '0 : prev_inc[OFF_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_rd <= '0;
    else         prev_rd <= rd_off;
  end

  p_req_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_addr_o));

  p_tbl_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tbl_valid_o && !tbl_ready_i |=> tbl_valid_o && $stable(tbl_id_o));

  p_dev_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tbl_valid_o && !tbl_coll_o |-> (tbl_id_o <= max_dev_id_i) && (tbl_size_o <= id_bits_i));

  p_coll_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tbl_valid_o && tbl_coll_o |-> (tbl_id_o <= {16'h0, max_coll_id_i}) && (tbl_cpu_o <= num_cpu_i));

  p_sync_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sync_o && tbl_valid_o));

  p_rd_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_off != prev_rd) |-> (rd_off == prev_nxt));

  p_stall_freeze_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_ptr_o[0]) |-> (rd_off == prev_rd));

  p_reject_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_err_o |-> (wr_ptr_o == $past(wr_ptr_o)));

  p_idle_quiet_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_valid_o && !tbl_valid_o && !sync_o);
endmodule

bind cmdq_engine cmdq_engine_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rd_ptr_o(rd_ptr_o), .wr_ptr_o(wr_ptr_o),
  .wr_err_o(wr_err_o), .busy_o(busy_o), .mem_req_valid_o(mem_req_valid_o),
  .mem_req_ready_i(mem_req_ready_i), .mem_addr_o(mem_addr_o),
  .tbl_valid_o(tbl_valid_o), .tbl_ready_i(tbl_ready_i), .tbl_coll_o(tbl_coll_o),
  .tbl_id_o(tbl_id_o), .tbl_size_o(tbl_size_o), .tbl_cpu_o(tbl_cpu_o),
  .sync_o(sync_o), .max_entries_i(max_entries_i), .max_dev_id_i(max_dev_id_i),
  .id_bits_i(id_bits_i), .max_coll_id_i(max_coll_id_i), .num_cpu_i(num_cpu_i)
);

// File: tb/cmdq_engine_tb.sv
`timescale 1ns/1ps
module cmdq_engine_tb;
  localparam int AW = 32;
  localparam int OW = 4;
  localparam int NENT = 8;
  localparam logic [31:0] BASE = 32'h0000_0400;
  localparam int MAXDEV = 100, IDB = 10, MAXCOLL = 15, NCPU = 3;

  typedef struct packed {
    logic coll; logic [31:0] id; logic v; logic [4:0] size; logic [43:0] itt; logic [15:0] cpu;
  } tbl_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0, reg_addr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] rd_ptr, wr_ptr;
  logic wr_err, busy, mreq_v, mreq_r = 1'b0, mrsp_v = 1'b0, mrsp_e = 1'b0;
  logic [AW-1:0] maddr;
  logic [63:0] mrsp_d = '0;
  logic tbl_v, tbl_r = 1'b0, tbl_e = 1'b0, tbl_coll, tbl_mv, sync;
  logic [31:0] tbl_id;
  logic [4:0] tbl_size;
  logic [43:0] tbl_itt;
  logic [15:0] tbl_cpu, sync_cpu;

  always #4 clk = ~clk;

  cmdq_engine #(.ADDR_W(AW), .OFF_W(OW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .base_addr_i(BASE), .max_entries_i((OW+1)'(NENT)),
    .max_dev_id_i(32'(MAXDEV)), .id_bits_i(5'(IDB)), .max_coll_id_i(16'(MAXCOLL)),
    .num_cpu_i(16'(NCPU)), .rd_ptr_o(rd_ptr), .wr_ptr_o(wr_ptr), .wr_err_o(wr_err),
    .busy_o(busy), .mem_req_valid_o(mreq_v), .mem_req_ready_i(mreq_r),
    .mem_addr_o(maddr), .mem_rsp_valid_i(mrsp_v), .mem_rsp_data_i(mrsp_d),
    .mem_rsp_err_i(mrsp_e), .tbl_valid_o(tbl_v), .tbl_ready_i(tbl_r),
    .tbl_err_i(tbl_e), .tbl_coll_o(tbl_coll), .tbl_id_o(tbl_id),
    .tbl_map_valid_o(tbl_mv), .tbl_size_o(tbl_size), .tbl_itt_o(tbl_itt),
    .tbl_cpu_o(tbl_cpu), .sync_o(sync), .sync_cpu_o(sync_cpu)
  );

  int nchk = 0, nfail = 0;
  bit done = 0;
  logic [63:0] mem [NENT*4];
  logic [31:0] exp_addr [$];
  tbl_t        exp_tbl [$];
  logic [15:0] exp_sync [$];
  logic [31:0] err_addr = '1;
  int m_rd = 0;
  logic m_stall = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] a_of(input int slot, input int dw);
    return BASE + 32'(slot * 32) + 32'(dw * 8);
  endfunction

  task automatic put(input int slot, input logic [63:0] w0, input logic [63:0] w1, input logic [63:0] w2);
    mem[slot*4] = w0; mem[slot*4+1] = w1; mem[slot*4+2] = w2; mem[slot*4+3] = '0;
  endtask
  task automatic put_mapd(input int slot, input logic [31:0] dev, input logic [4:0] sz,
                          input logic [43:0] itt, input logic v);
    put(slot, {dev, 24'h0, 8'h08}, {59'h0, sz}, {v, 11'h0, itt, 8'h0});
  endtask
  task automatic put_mapc(input int slot, input logic [15:0] coll, input logic [15:0] cpu, input logic v);
    put(slot, 64'h09, 64'h0, {v, 31'h0, cpu, coll});
  endtask
  task automatic put_op(input int slot, input logic [7:0] op, input logic [15:0] cpu);
    put(slot, {56'h0, op}, 64'h0, {32'h0, cpu, 16'h0});
  endtask

  // scoreboard driver: expected fetches, table items and sync pulses for one slot
  task automatic expect_slot(input int slot);
    logic [63:0] w0, w1, w2;
    tbl_t t;
    w0 = mem[slot*4]; w1 = mem[slot*4+1]; w2 = mem[slot*4+2];
    exp_addr.push_back(a_of(slot, 0));
    t = '0;
    case (w0[7:0])
      8'h08: begin
        exp_addr.push_back(a_of(slot, 1));
        exp_addr.push_back(a_of(slot, 2));
        if (w0[63:32] <= MAXDEV && w1[4:0] <= IDB) begin
          t.id = w0[63:32]; t.v = w2[63]; t.size = w1[4:0]; t.itt = w2[51:8];
          exp_tbl.push_back(t);
        end
      end
      8'h09: begin
        exp_addr.push_back(a_of(slot, 2));
        if (w2[15:0] <= MAXCOLL && w2[31:16] <= NCPU) begin
          t.coll = 1'b1; t.id = {16'h0, w2[15:0]}; t.v = w2[63]; t.cpu = w2[31:16];
          exp_tbl.push_back(t);
        end
      end
      8'h05: begin
        exp_addr.push_back(a_of(slot, 2));
        exp_sync.push_back(w2[31:16]);
      end
      default: ;
    endcase
  endtask

  task automatic reg_write(input logic a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic wait_idle();
    int n;
    @(negedge clk);
    n = 0;
    while (busy && n < 2000) begin @(negedge clk); n++; end
    repeat (2) @(negedge clk);
  endtask

  task automatic run_to(input int wr, input string req);
    while (m_rd != wr) begin
      expect_slot(m_rd);
      m_rd = (m_rd + 1) % NENT;
    end
    reg_write(1'b1, 32'(wr) << 5);
    wait_idle();
    chk(rd_ptr == ((32'(wr) << 5) | 32'(m_stall)), req, "read pointer after run", rd_ptr,
        (32'(wr) << 5) | 32'(m_stall));
    chk(exp_addr.size() == 0 && exp_tbl.size() == 0 && exp_sync.size() == 0, req,
        "scoreboard drained", 128'(exp_addr.size() + exp_tbl.size() + exp_sync.size()), 0);
  endtask

  // memory, table and sync monitor
  initial begin
    int pend, cyc, idx;
    logic [31:0] ra;
    tbl_t a;
    pend = -1; cyc = 0; ra = '0;
    forever begin
      @(negedge clk);
      cyc++;
      mrsp_v = 1'b0; mrsp_e = 1'b0;
      if (pend == 0) begin
        idx = int'((ra - BASE) >> 3);
        mrsp_v = 1'b1;
        mrsp_d = (idx >= 0 && idx < NENT*4) ? mem[idx] : 64'h0;
        mrsp_e = (ra == err_addr);
        pend = -1;
      end else if (pend > 0) pend--;
      mreq_r = (cyc % 3) != 2;
      if (mreq_v && mreq_r) begin
        ra = maddr;
        pend = cyc % 2;
        if (exp_addr.size() == 0) chk(1'b0, "R4", "unexpected fetch", maddr, 0);
        else begin
          logic [31:0] e;
          e = exp_addr.pop_front();
          chk(maddr == e, "R4", "fetch address", maddr, e);
        end
      end
      tbl_r = (cyc % 4) != 1;
      if (tbl_v && tbl_r) begin
        a = {tbl_coll, tbl_id, tbl_mv, tbl_size, tbl_itt, tbl_cpu};
        if (tbl_coll) begin a.size = '0; a.itt = '0; end
        else a.cpu = '0;
        if (exp_tbl.size() == 0) chk(1'b0, "R7", "unexpected table request", a, 0);
        else begin
          tbl_t e;
          e = exp_tbl.pop_front();
          chk(a == e, "R5 R6", "table request", a, e);
        end
      end
      if (sync) begin
        if (exp_sync.size() == 0) chk(1'b0, "R8", "unexpected sync", sync_cpu, 0);
        else begin
          logic [15:0] e;
          e = exp_sync.pop_front();
          chk(sync_cpu == e, "R8", "sync cpu", sync_cpu, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NENT*4; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(rd_ptr == 0 && wr_ptr == 0, "R1", "pointers after reset", {rd_ptr, wr_ptr}, 0);
    chk(!busy && !mreq_v && !tbl_v && !sync && !wr_err, "R1", "outputs after reset",
        {busy, mreq_v, tbl_v, sync, wr_err}, 0);

    put_mapd(0, 32'd7, 5'd5, 44'h123_4567_89AB, 1'b1);
    put_mapc(1, 16'd4, 16'd2, 1'b1);

    // R12 / R2: disabled write stores but does not start
    reg_write(1'b1, 32'h41);
    chk(wr_ptr == 32'h41, "R2", "write pointer with retry bit", wr_ptr, 32'h41);
    repeat (4) @(negedge clk);
    chk(!busy && rd_ptr == 0, "R12", "no start while disabled", {busy, rd_ptr}, 0);
    reg_write(1'b0, 32'h1);
    repeat (4) @(negedge clk);
    chk(!busy && rd_ptr == 0, "R12", "enable alone does not start", {busy, rd_ptr}, 0);

    // R2 R5 R6
    run_to(2, "R2");

    // R3: offset 9 and 8 both rejected
    @(negedge clk); reg_we = 1'b1; reg_addr = 1'b1; reg_wdata = 32'(9) << 5;
    @(negedge clk); reg_we = 1'b0;
    chk(wr_err == 1'b1, "R3", "error pulse for offset 9", wr_err, 1);
    chk(wr_ptr == 32'h40, "R3", "pointer kept", wr_ptr, 32'h40);
    @(negedge clk);
    chk(wr_err == 1'b0, "R3", "error pulse one cycle", wr_err, 0);
    @(negedge clk); reg_we = 1'b1; reg_wdata = 32'(8) << 5;
    @(negedge clk); reg_we = 1'b0;
    chk(wr_err == 1'b1 && wr_ptr == 32'h40, "R3", "offset equal to count rejected", {wr_err, wr_ptr}, {1'b1, 32'h40});
    repeat (3) @(negedge clk);
    chk(!busy, "R3", "no run after reject", busy, 0);

    // R7 R8
    put_op(2, 8'h05, 16'd2);
    put_mapd(3, 32'd200, 5'd3, 44'h1, 1'b1);
    put_mapd(4, 32'd5, 5'd11, 44'h2, 1'b1);
    put_mapc(5, 16'd2, 16'd4, 1'b1);
    put_op(6, 8'h7e, 16'd0);
    run_to(7, "R7");

    // R9 wrap, boundary operands
    put_mapc(7, 16'd15, 16'd3, 1'b0);
    put_op(0, 8'h0F, 16'd0);
    put_mapd(1, 32'd100, 5'd10, 44'hFFF_0000_0001, 1'b1);
    run_to(2, "R9");

    // R10: read error on dw1
    put_mapd(2, 32'd9, 5'd1, 44'h77, 1'b1);
    exp_addr.push_back(a_of(2, 0));
    exp_addr.push_back(a_of(2, 1));
    err_addr = a_of(2, 1);
    reg_write(1'b1, 32'(3) << 5);
    wait_idle();
    chk(rd_ptr == ((32'(2) << 5) | 1), "R10", "stall on read error", rd_ptr, (32'(2) << 5) | 1);
    chk(!busy, "R10", "stopped after stall", busy, 0);
    err_addr = '1;
    m_stall = 1'b1;
    run_to(3, "R10");

    // R10: table error
    put_mapc(3, 16'd1, 16'd1, 1'b1);
    exp_addr.push_back(a_of(3, 0));
    exp_addr.push_back(a_of(3, 2));
    exp_tbl.push_back('{coll: 1'b1, id: 32'd1, v: 1'b1, size: '0, itt: '0, cpu: 16'd1});
    tbl_e = 1'b1;
    reg_write(1'b1, 32'(4) << 5);
    wait_idle();
    chk(rd_ptr == ((32'(3) << 5) | 1), "R10", "stall on table error", rd_ptr, (32'(3) << 5) | 1);
    tbl_e = 1'b0;
    run_to(4, "R10");

    // R11: write while busy
    put_op(4, 8'h0A, 16'd0);
    put_op(5, 8'h0B, 16'd0);
    put_op(6, 8'h05, 16'd1);
    for (int s = 4; s < 7; s++) expect_slot(s);
    m_rd = 7;
    reg_write(1'b1, 32'(5) << 5);
    @(negedge clk);
    chk(busy == 1'b1, "R11", "busy before second write", busy, 1);
    reg_write(1'b1, 32'(7) << 5);
    wait_idle();
    chk(rd_ptr == ((32'(7) << 5) | 1), "R11", "ran to later pointer", rd_ptr, (32'(7) << 5) | 1);

    // R8 remaining no-op codes, wrap again
    put_op(7, 8'h03, 16'd0);
    put_op(0, 8'h04, 16'd0);
    run_to(1, "R8");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule